// File: doc/BRIEF.md
# Predicated SIMD Lane Write-Enable Unit

This block sits at the write-back edge of a 64-bit SIMD ALU, in front of a register file that has one write enable per byte. It takes a single 32-bit read of eight 4-bit condition fields and picks one predicate bit from each field. A 2-bit selector chooses the bit, unless a build-time option pins it to bit 0. The eight bits can be complemented as a group by one opcode bit, or replaced by all ones when predication is off.

The chosen bits are spread over the element lanes given by the element width. One bit covers a 64-bit element, two cover 32-bit elements, four cover 16-bit elements and eight cover bytes. In non-zeroing mode the spread mask drives the byte write enables directly, so masked-out destination bytes keep their old value with no read-modify-write. In zeroing mode every byte is written, and masked-out bytes carry zero. Write data and enables leave the block one clock after the input, together with a valid flag.

Top module: `lane_pred_wen`

## Requirements
- R1: Predicate bit i comes from condition field i, which is input bits [4i+3:4i]. Within the field, bit `pred_sel` (0 to 3) is used. Predicate bit i governs element lane i, and lane 0 is the least significant element.
- R2: When the parameter FIXED_BIT0 is 1, bit 0 of every field is used whatever `pred_sel` holds.
- R3: When `pred_inv` is 1, every extracted predicate bit is complemented before it is used.
- R4: When `pred_en` is 0, the predicate is all ones whatever `cr_fields` and `pred_inv` hold.
- R5: `elem_w` encodes 2'b00 = 64-bit, 2'b01 = 32-bit, 2'b10 = 16-bit and 2'b11 = 8-bit elements. Byte b belongs to lane b / (8 >> elem_w), and takes that lane's predicate bit.
- R6: Predicate bits at or above the lane count of the element width (8 >> (3 - elem_w) lanes) have no effect on the outputs.
- R7: In non-zeroing mode (`zero_mode` = 0), `wr_be` equals the byte mask and `wr_data` equals `alu_data` unchanged.
- R8: In zeroing mode, `wr_be` is 8'hFF. Bytes whose mask bit is 0 carry 8'h00, and the other bytes carry the `alu_data` byte.
- R9: `wr_valid` is `in_valid` delayed by one clock. The outputs for an input appear on that same delayed cycle.
- R10: While `rst_n` is low, and on any cycle where `wr_valid` is 0, `wr_be` is 0. Reset is synchronous and active low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A result is present on the inputs this cycle |
| alu_data | input | 64 | SIMD ALU result |
| cr_fields | input | 32 | Eight 4-bit condition fields, field i at bits [4i+3:4i] |
| pred_sel | input | 2 | Bit chosen within each field |
| pred_inv | input | 1 | Complement the predicate |
| pred_en | input | 1 | Predication on; 0 gives an all-ones predicate |
| zero_mode | input | 1 | 1 = zeroing, 0 = non-zeroing |
| elem_w | input | 2 | Element width code |
| wr_valid | output | 1 | Registered valid |
| wr_data | output | 64 | Registered write data |
| wr_be | output | 8 | Registered byte write enables |

## Verification
A fault in field selection, inversion or lane spreading shows up as a wrong `wr_be` bit in non-zeroing mode, or as a stray 8'h00 byte (or a missing one) in zeroing mode. It appears on the cycle after the input, because only one register stage lies between the inputs and the outputs. A fault in the valid or reset path shows as `wr_be` bits set on an idle cycle, or as a result that arrives a cycle early or late. The scoreboard's ordering exposes both at once. Spreading faults that touch only upper lanes are caught by running the narrow widths with field patterns that differ between lanes.

// File: rtl/lpw_pkg.sv
package lpw_pkg;

  typedef enum logic [1:0] {
    EW_64 = 2'b00,
    EW_32 = 2'b01,
    EW_16 = 2'b10,
    EW_8  = 2'b11
  } elem_width_e;

  // Lane index owning byte b: each width step halves the bytes per lane.
  function automatic int lane_of_byte(input int b, input logic [1:0] ew);
    return b >> (3 - int'(ew));
  endfunction

  // Zeroing keeps a byte only when its mask bit is set.
  function automatic logic [7:0] keep_byte(input logic [7:0] d, input logic m);
    return m ? d : 8'h00;
  endfunction

endpackage

// File: rtl/pred_extract.sv
module pred_extract #(
  parameter int NUM_FIELDS = 8,
  parameter int FIELD_W    = 4,
  parameter bit FIXED_BIT0 = 1'b0,
  localparam int SEL_W     = $clog2(FIELD_W),
  localparam int CR_W      = NUM_FIELDS * FIELD_W
) (
  input  logic [CR_W-1:0]       cr,
  input  logic [SEL_W-1:0]      sel,
  input  logic                  inv,
  input  logic                  en,
  output logic [NUM_FIELDS-1:0] pred
);

  logic [SEL_W-1:0] eff_sel;
  assign eff_sel = sel & {SEL_W{~FIXED_BIT0}};

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    logic [FIELD_W-1:0] fld;
    logic               picked;
    assign fld     = cr[i*FIELD_W +: FIELD_W];
    assign picked  = fld[eff_sel] ^ inv;
    assign pred[i] = picked | ~en;
  end

endmodule

// File: rtl/lane_expand.sv
module lane_expand #(
  parameter int BYTES     = 8,
  parameter int NUM_LANES = 8,
  localparam int LANE_IW  = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
  input  logic [NUM_LANES-1:0] pred,
  input  logic [1:0]           ew,
  output logic [BYTES-1:0]     mask
);

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    logic [LANE_IW-1:0] lane;
    always_comb begin
      lane    = LANE_IW'(lpw_pkg::lane_of_byte(b, ew));
      mask[b] = pred[lane];
    end
  end

endmodule

// File: rtl/byte_merge.sv
module byte_merge #(
  parameter int BYTES    = 8,
  localparam int DATA_W  = BYTES * 8
) (
  input  logic [DATA_W-1:0] din,
  input  logic [BYTES-1:0]  mask,
  input  logic              zero_mode,
  output logic [DATA_W-1:0] dout,
  output logic [BYTES-1:0]  be
);

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    logic [7:0] zeroed;
    assign zeroed         = lpw_pkg::keep_byte(din[b*8 +: 8], mask[b]);
    assign dout[b*8 +: 8] = zero_mode ? zeroed : din[b*8 +: 8];
    assign be[b]          = zero_mode | mask[b];
  end

endmodule

// File: rtl/lane_pred_wen.sv
module lane_pred_wen #(
  parameter int DATA_W     = 64,
  parameter int FIELD_W    = 4,
  parameter bit FIXED_BIT0 = 1'b0,
  localparam int BYTES     = DATA_W / 8,
  localparam int NUM_FIELDS = BYTES,
  localparam int CR_W      = NUM_FIELDS * FIELD_W,
  localparam int SEL_W     = $clog2(FIELD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] alu_data,
  input  logic [CR_W-1:0]   cr_fields,
  input  logic [SEL_W-1:0]  pred_sel,
  input  logic              pred_inv,
  input  logic              pred_en,
  input  logic              zero_mode,
  input  logic [1:0]        elem_w,
  output logic              wr_valid,
  output logic [DATA_W-1:0] wr_data,
  output logic [BYTES-1:0]  wr_be
);

  logic [NUM_FIELDS-1:0] pred_bits;
  logic [BYTES-1:0]      lane_byte_mask;
  logic [DATA_W-1:0]     merged_data;
  logic [BYTES-1:0]      merged_be;

  pred_extract #(
    .NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W), .FIXED_BIT0(FIXED_BIT0)
  ) u_extract (
    .cr(cr_fields), .sel(pred_sel), .inv(pred_inv), .en(pred_en), .pred(pred_bits)
  );

  lane_expand #(.BYTES(BYTES), .NUM_LANES(NUM_FIELDS)) u_expand (
    .pred(pred_bits), .ew(elem_w), .mask(lane_byte_mask)
  );

  byte_merge #(.BYTES(BYTES)) u_merge (
    .din(alu_data), .mask(lane_byte_mask), .zero_mode(zero_mode),
    .dout(merged_data), .be(merged_be)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_be    <= '0;
    end else begin
      wr_valid <= in_valid;
      wr_be    <= in_valid ? merged_be : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) wr_data <= merged_data;
  end

endmodule

// File: rtl/lane_pred_wen_chk.sv
module lane_pred_wen_chk #(
  parameter int BYTES = 8,
  localparam int DATA_W = BYTES * 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              pred_en,
  input logic              zero_mode,
  input logic [1:0]        elem_w,
  input logic [DATA_W-1:0] alu_data,
  input logic [BYTES-1:0]  lane_byte_mask,
  input logic              wr_valid,
  input logic [DATA_W-1:0] wr_data,
  input logic [BYTES-1:0]  wr_be
);

  a_r9_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid == $past(in_valid));

  a_r10_idle_no_we: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |-> wr_be == '0);

  a_r8_zero_all_we: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && $past(zero_mode)) |-> &wr_be);

  a_r7_nz_data_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !$past(zero_mode)) |-> wr_data == $past(alu_data));

  a_r4_bypass_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !pred_en) |-> &lane_byte_mask);

  a_r5_w64_uniform: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && elem_w == 2'b00) |-> ($countones(lane_byte_mask) == 0 ||
                                       $countones(lane_byte_mask) == BYTES));

endmodule

bind lane_pred_wen lane_pred_wen_chk #(.BYTES(BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pred_en(pred_en),
  .zero_mode(zero_mode), .elem_w(elem_w), .alu_data(alu_data),
  .lane_byte_mask(lane_byte_mask), .wr_valid(wr_valid), .wr_data(wr_data),
  .wr_be(wr_be)
);

// File: tb/lane_pred_wen_bench.sv
`timescale 1ns/1ps
module lane_pred_wen_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] alu_data = '0;
  logic [31:0] cr_fields = '0;
  logic [1:0]  pred_sel = '0;
  logic        pred_inv = 1'b0;
  logic        pred_en = 1'b0;
  logic        zero_mode = 1'b0;
  logic [1:0]  elem_w = '0;
  logic        va, vb;
  logic [63:0] da, db;
  logic [7:0]  ba, bb;

  always #2 clk = ~clk;

  lane_pred_wen u_lane_pred_wen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .alu_data(alu_data),
    .cr_fields(cr_fields), .pred_sel(pred_sel), .pred_inv(pred_inv),
    .pred_en(pred_en), .zero_mode(zero_mode), .elem_w(elem_w),
    .wr_valid(va), .wr_data(da), .wr_be(ba)
  );

  lane_pred_wen #(.FIXED_BIT0(1'b1)) u_lane_pred_wen_fixed (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .alu_data(alu_data),
    .cr_fields(cr_fields), .pred_sel(pred_sel), .pred_inv(pred_inv),
    .pred_en(pred_en), .zero_mode(zero_mode), .elem_w(elem_w),
    .wr_valid(vb), .wr_data(db), .wr_be(bb)
  );

  typedef struct {
    logic [63:0] d;
    logic [7:0]  we;
    string       tag;
  } exp_t;

  exp_t qa[$];
  exp_t qb[$];
  int   n_checks = 0;
  int   n_fails  = 0;
  bit   done     = 1'b0;

  function automatic exp_t model(input logic [63:0] alu, input logic [31:0] cr,
                                 input logic [1:0] sel, input logic inv,
                                 input logic en, input logic zm,
                                 input logic [1:0] ew, input bit fixed,
                                 input string tag);
    exp_t e;
    logic [7:0] p;
    for (int i = 0; i < 8; i++) begin
      int pos;
      pos = i * 4 + (fixed ? 0 : int'(sel));
      p[i] = en ? (cr[pos] ^ inv) : 1'b1;
    end
    for (int b = 0; b < 8; b++) begin
      int  per;
      logic m;
      per = 8 >> ew;
      m = p[b / per];
      e.we[b] = zm ? 1'b1 : m;
      e.d[b*8 +: 8] = (zm && !m) ? 8'h00 : alu[b*8 +: 8];
    end
    e.tag = tag;
    return e;
  endfunction

  task automatic check(input string tag, input logic [63:0] act,
                       input logic [63:0] exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic [63:0] alu, input logic [31:0] cr,
                       input logic [1:0] sel, input logic inv, input logic en,
                       input logic zm, input logic [1:0] ew, input string tag);
    @(negedge clk);
    in_valid = 1'b1; alu_data = alu; cr_fields = cr; pred_sel = sel;
    pred_inv = inv; pred_en = en; zero_mode = zm; elem_w = ew;
    qa.push_back(model(alu, cr, sel, inv, en, zm, ew, 1'b0, tag));
    qb.push_back(model(alu, cr, sel, inv, en, zm, ew, 1'b1, tag));
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      alu_data = 64'hDEAD_BEEF_0BAD_F00D;
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  // Monitor: pops the oldest expected item whenever a result appears.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (va) begin
        if (qa.size() == 0) check("R9", 64'd1, 64'd0, "unexpected valid (main)");
        else begin
          exp_t e;
          e = qa.pop_front();
          check(e.tag, 64'(ba), 64'(e.we), "main wr_be");
          check(e.tag, da, e.d, "main wr_data");
        end
      end else check("R10", 64'(ba), 64'd0, "main idle wr_be");
      if (vb) begin
        if (qb.size() == 0) check("R9", 64'd1, 64'd0, "unexpected valid (fixed)");
        else begin
          exp_t e;
          e = qb.pop_front();
          check(e.tag == "R1" ? "R2" : e.tag, 64'(bb), 64'(e.we), "fixed wr_be");
          check(e.tag, db, e.d, "fixed wr_data");
        end
      end else check("R10", 64'(bb), 64'd0, "fixed idle wr_be");
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    done = 1'b1;
    finish_run();
  end

  initial begin
    logic [63:0] d;
    d = 64'h8877_6655_4433_2211;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", {62'd0, va, vb}, 64'd0, "valid during reset");
    check("R10", {48'd0, ba, bb}, 64'd0, "wr_be during reset");
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    // R1: each bit position of the fields, 8-bit lanes, distinct per field
    for (int s = 0; s < 4; s++) drive(d, 32'h8421_C3A5, 2'(s), 1'b0, 1'b1, 1'b0, 2'b11, "R1");
    drive(d, 32'h0000_000F, 2'd2, 1'b0, 1'b1, 1'b0, 2'b11, "R1");
    drive(d, 32'hF000_0000, 2'd3, 1'b0, 1'b1, 1'b0, 2'b11, "R1");
    // R3: inversion
    drive(d, 32'h8421_C3A5, 2'd1, 1'b1, 1'b1, 1'b0, 2'b11, "R3");
    drive(d, 32'h0000_0000, 2'd0, 1'b1, 1'b1, 1'b1, 2'b11, "R3");
    // R4: predication off overrides fields and inversion
    drive(d, 32'h0000_0000, 2'd0, 1'b1, 1'b0, 1'b0, 2'b11, "R4");
    drive(d, 32'hFFFF_FFFF, 2'd3, 1'b1, 1'b0, 1'b1, 2'b10, "R4");
    // R5: each width
    for (int w = 0; w < 4; w++) drive(d, 32'h1010_0101, 2'd0, 1'b0, 1'b1, 1'b0, 2'(w), "R5");
    drive(d, 32'h0000_0010, 2'd0, 1'b0, 1'b1, 1'b0, 2'b01, "R5");
    // R6: upper predicate bits ignored at wide elements
    drive(d, 32'hFFFF_FFF0, 2'd0, 1'b0, 1'b1, 1'b0, 2'b00, "R6");
    drive(d, 32'h0000_0001, 2'd0, 1'b0, 1'b1, 1'b0, 2'b00, "R6");
    drive(d, 32'hFFFF_FF00, 2'd0, 1'b0, 1'b1, 1'b1, 2'b01, "R6");
    idle(1);
    // R7 / R8: non-zeroing and zeroing, back to back
    drive(64'hFFFF_FFFF_FFFF_FFFF, 32'h0110_1001, 2'd0, 1'b0, 1'b1, 1'b0, 2'b11, "R7");
    drive(64'hFFFF_FFFF_FFFF_FFFF, 32'h0110_1001, 2'd0, 1'b0, 1'b1, 1'b1, 2'b11, "R8");
    drive(d, 32'h1111_1111, 2'd0, 1'b1, 1'b1, 1'b1, 2'b10, "R8");
    idle(2);
    // R9: random traffic with gaps
    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(3) == 0) idle(1);
      drive({$urandom, $urandom}, $urandom, 2'($urandom), 1'($urandom),
            1'($urandom_range(4) != 0), 1'($urandom), 2'($urandom), "R9");
    end
    idle(3);
    check("R9", 64'(qa.size() + qb.size()), 64'd0, "results outstanding");
    // R10: synchronous reset clears outputs
    drive(d, 32'hFFFF_FFFF, 2'd0, 1'b0, 1'b1, 1'b0, 2'b11, "R10");
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    qa.delete(); qb.delete();
    @(negedge clk);
    check("R10", {48'd0, ba, bb}, 64'd0, "wr_be after reset");
    check("R10", {62'd0, va, vb}, 64'd0, "valid after reset");
    done = 1'b1;
    finish_run();
  end

endmodule